// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block runs a scatter-gather DMA by walking a linked list of descriptors in host memory. Software starts it by writing the physical address of the first descriptor to a pointer write port. The walker fetches each descriptor as three consecutive 32-bit words through a simple memory read handshake. The words are the transfer address, the byte length and a next-pointer word. For each descriptor it issues one request to the data mover. It then follows the next pointer until a descriptor marks the end of the chain.

The two low bits of every next-pointer word are flags. Bit 0 gives the transfer direction and must match the engine's fixed direction. Bit 1 marks the last descriptor. A direction mismatch, a failed fetch or a failed transfer raises a sticky error and stops the chain. Writing an address of zero aborts a chain in flight. A done flag, together with an interrupt gated by an enable input, reports that a chain completed normally.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, busy, done, err, irq, mem_req and xfer_req are all 0.
- R2: While idle, a pointer write whose bits 31:2 are not all zero starts a chain. The next cycle, busy is 1 and the first fetch targets the written value with bits 1:0 forced to 0.
- R3: Each descriptor is fetched as three words at P, P+4 and P+8, in that order: transfer address, byte length, next-pointer word. mem_req and mem_addr hold steady until mem_ack.
- R4: Each accepted descriptor produces exactly one transfer request carrying its address and length. The request is held steady until xfer_ack and is never active in the same cycle as mem_req.
- R5: In the next-pointer word, bit 1 is end of chain. When it is clear, the next descriptor is fetched from bits 31:2 with bits 1:0 set to zero. When it is set, the chain ends after that descriptor's transfer is acknowledged.
- R6: done rises when the end-of-chain transfer is acknowledged without error, and is cleared by the next start.
- R7: If bit 0 of a next-pointer word differs from parameter ENG_DIR, err is set and the chain stops without a transfer request for that descriptor.
- R8: mem_err high with mem_ack, or xfer_err high with xfer_ack, sets err and stops the chain.
- R9: err stays set until the next start, which clears it.
- R10: A pointer write whose bits 31:2 are all zero aborts a running chain. The next cycle, busy, mem_req and xfer_req are 0, and done is not set. While idle, such a write changes nothing.
- R11: A pointer write with a nonzero address while busy is ignored, and the running chain continues unchanged.
- R12: irq is high exactly when done and irq_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 32 | Value written to the pointer register |
| irq_en | input | 1 | Done interrupt enable |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_ack | input | 1 | Read accepted, mem_rdata valid |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Bus abort on this read, valid with mem_ack |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Transfer start address |
| xfer_len | output | 32 | Transfer length in bytes |
| xfer_ack | input | 1 | Transfer completed |
| xfer_err | input | 1 | Transfer failed, valid with xfer_ack |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Last chain completed normally |
| err | output | 1 | Sticky DMA error |
| irq | output | 1 | Done interrupt |

## Verification
The bench builds the walker with ENG_DIR = 1. With that setting, a next-pointer word that has bit 0 cleared is a direction mismatch, so the bench can place one in a chain just by leaving the flag bit out. The bench's memory model can stall the transfer acknowledge. This keeps a request pending long enough for an abort or an ignored pointer write to land mid-chain. It can also inject bus aborts at chosen fetch or transfer addresses.

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
  parameter bit ENG_DIR = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr,
  input  logic [31:0] ptr_wdata,
  input  logic        irq_en,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        xfer_req,
  output logic [31:0] xfer_addr,
  output logic [31:0] xfer_len,
  input  logic        xfer_ack,
  input  logic        xfer_err,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        irq
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} st_t;

  st_t         st;
  logic [31:0] ptr;
  logic [31:0] d_addr;
  logic [31:0] d_len;
  logic [29:0] d_next;
  logic        d_last;
  logic [1:0]  widx;

  wire abort = ptr_wr && (ptr_wdata[31:2] == 30'd0);
  wire start = ptr_wr && (ptr_wdata[31:2] != 30'd0) && (st == S_IDLE);

  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = ptr + {28'd0, widx, 2'b00};
  assign xfer_req  = (st == S_XFER);
  assign xfer_addr = d_addr;
  assign xfer_len  = d_len;
  assign busy      = (st != S_IDLE);
  assign irq       = done & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      d_addr <= '0;
      d_len  <= '0;
      d_next <= '0;
      d_last <= 1'b0;
      widx   <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (abort) begin
      st   <= S_IDLE;
      widx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ptr  <= {ptr_wdata[31:2], 2'b00};
          widx <= '0;
          done <= 1'b0;
          err  <= 1'b0;
          st   <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err  <= 1'b1;
            widx <= '0;
            st   <= S_IDLE;
          end else begin
            case (widx)
              2'd0: begin d_addr <= mem_rdata; widx <= 2'd1; end
              2'd1: begin d_len  <= mem_rdata; widx <= 2'd2; end
              default: begin
                d_next <= mem_rdata[31:2];
                d_last <= mem_rdata[1];
                widx   <= '0;
                if (mem_rdata[0] != ENG_DIR) begin
                  err <= 1'b1;
                  st  <= S_IDLE;
                end else begin
                  st  <= S_XFER;
                end
              end
            endcase
          end
        end
        S_XFER: if (xfer_ack) begin
          if (xfer_err) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (d_last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            ptr <= {d_next, 2'b00};
            st  <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_req && (mem_addr == {$past(ptr_wdata[31:2]), 2'b00}));

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !abort |=> mem_req && $stable(mem_addr));

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack && !abort |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));

  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer_req && xfer_ack && !xfer_err));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !mem_req && !xfer_req);

  // R11
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr && busy && !abort && !(xfer_req && xfer_ack) |=> $stable(ptr));

endmodule

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        irq_en = 1'b0;
  logic        mem_req, xfer_req, busy, done, err, irq;
  logic [31:0] mem_addr, xfer_addr, xfer_len;
  logic        mem_ack = 1'b0, mem_err = 1'b0, xfer_ack = 1'b0, xfer_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  sg_chain_walker #(.ENG_DIR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .irq_en(irq_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err), .busy(busy), .done(done), .err(err), .irq(irq));

  always #5 clk = ~clk;

  logic [31:0] mem [128];
  logic [31:0] fa_log [32];
  logic [31:0] xa_log [16];
  logic [31:0] xl_log [16];
  int nf, nx, nchk, nerr;
  logic        hold_x = 1'b0;
  logic [31:0] bad_m = 32'hFFFF_FFFF, bad_x = 32'hFFFF_FFFF;
  bit          finished = 1'b0;

  initial forever begin
    @(negedge clk);
    mem_ack   = mem_req;
    mem_rdata = mem[mem_addr[8:2]];
    mem_err   = mem_req && (mem_addr == bad_m);
    if (mem_req && nf < 32) begin fa_log[nf] = mem_addr; nf++; end
    xfer_ack = xfer_req && !hold_x;
    xfer_err = xfer_req && (xfer_addr == bad_x);
    if (xfer_ack && nx < 16) begin xa_log[nx] = xfer_addr; xl_log[nx] = xfer_len; nx++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] xa, input logic [31:0] xl,
                          input logic [31:0] nxt);
    mem[a/4] = xa; mem[a/4+1] = xl; mem[a/4+2] = nxt;
  endtask

  task automatic wr_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    chk(1'b0, "R2", "chain never finished", {31'd0, busy}, 32'd0);
  endtask

  task automatic clr_logs();
    nf = 0; nx = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !irq, "R1", "status after reset",
        {28'd0, busy, done, err, irq}, 32'd0);
    chk(!mem_req && !xfer_req, "R1", "requests after reset", {30'd0, mem_req, xfer_req}, 32'd0);
  endtask

  task automatic t_chain3();
    clr_logs(); irq_en = 1'b1;
    wr_ptr(32'h43);
    chk(busy, "R2", "busy after start", {31'd0, busy}, 32'd1);
    wait_idle();
    chk(fa_log[0] == 32'h40, "R2", "first fetch low bits ignored", fa_log[0], 32'h40);
    chk(fa_log[1] == 32'h44 && fa_log[2] == 32'h48, "R3", "word order", fa_log[2], 32'h48);
    chk(nf == 9, "R3", "fetch count", nf, 9);
    chk(fa_log[3] == 32'h60 && fa_log[6] == 32'h80, "R5", "next pointer followed", fa_log[6], 32'h80);
    chk(nx == 3, "R4", "transfer count", nx, 3);
    chk(xa_log[0] == 32'h1000 && xl_log[0] == 16, "R4", "desc0 fields", xa_log[0], 32'h1000);
    chk(xa_log[2] == 32'h3000 && xl_log[2] == 48, "R4", "desc2 fields", xl_log[2], 48);
    chk(done && !err, "R6", "done after chain", {30'd0, done, err}, 32'd2);
    chk(irq, "R12", "irq with enable", {31'd0, irq}, 32'd1);
    irq_en = 1'b0; @(negedge clk);
    chk(!irq, "R12", "irq masked", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_idle_abort();
    wr_ptr(32'h0);
    chk(done && !busy, "R10", "zero write while idle", {30'd0, done, busy}, 32'd2);
  endtask

  task automatic t_single();
    clr_logs(); irq_en = 1'b0;
    wr_ptr(32'hA0);
    chk(!done, "R6", "done cleared by start", {31'd0, done}, 32'd0);
    wait_idle();
    chk(nx == 1 && xa_log[0] == 32'h4000, "R5", "single descriptor", xa_log[0], 32'h4000);
    chk(done && !irq, "R12", "done without irq", {30'd0, done, irq}, 32'd2);
  endtask

  task automatic t_dir();
    clr_logs();
    wr_ptr(32'hC0);
    wait_idle();
    chk(nx == 1, "R7", "no transfer after mismatch", nx, 1);
    chk(nf == 6, "R7", "fetches before mismatch", nf, 6);
    chk(err && !done, "R7", "err on mismatch", {30'd0, err, done}, 32'd2);
    repeat (5) @(negedge clk);
    chk(err, "R9", "err sticky while idle", {31'd0, err}, 32'd1);
  endtask

  task automatic t_mem_err();
    clr_logs(); bad_m = 32'h64;
    wr_ptr(32'h40);
    chk(!err, "R9", "err cleared by start", {31'd0, err}, 32'd0);
    wait_idle();
    bad_m = 32'hFFFF_FFFF;
    chk(err && !done && nx == 1, "R8", "fetch abort", nx, 1);
  endtask

  task automatic t_xfer_err();
    clr_logs(); bad_x = 32'h2000;
    wr_ptr(32'h40);
    wait_idle();
    bad_x = 32'hFFFF_FFFF;
    chk(err && !done, "R8", "transfer abort flags", {30'd0, err, done}, 32'd2);
    chk(nx == 2 && nf == 6, "R8", "chain stopped after failed transfer", nf, 6);
  endtask

  task automatic t_abort();
    clr_logs(); hold_x = 1'b1;
    wr_ptr(32'h40);
    for (int i = 0; i < 50 && !xfer_req; i++) @(negedge clk);
    wr_ptr(32'h0);
    chk(!busy && !xfer_req && !mem_req, "R10", "abort stops chain",
        {29'd0, busy, xfer_req, mem_req}, 32'd0);
    chk(!done && nx == 0, "R10", "no done after abort", {31'd0, done}, 32'd0);
    hold_x = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && nx == 0, "R10", "stays idle after abort", nx, 0);
  endtask

  task automatic t_ignore();
    clr_logs(); hold_x = 1'b1;
    wr_ptr(32'h40);
    for (int i = 0; i < 50 && !xfer_req; i++) @(negedge clk);
    wr_ptr(32'hA0);
    chk(busy && xfer_req && xfer_addr == 32'h1000, "R11", "write while busy ignored",
        xfer_addr, 32'h1000);
    hold_x = 1'b0;
    wait_idle();
    chk(nx == 3 && xa_log[1] == 32'h2000 && done, "R11", "original chain completes",
        xa_log[1], 32'h2000);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    put_desc(32'h40, 32'h1000, 16, 32'h61);
    put_desc(32'h60, 32'h2000, 32, 32'h81);
    put_desc(32'h80, 32'h3000, 48, 32'h3);
    put_desc(32'hA0, 32'h4000, 8,  32'h3);
    put_desc(32'hC0, 32'h5000, 4,  32'hD1);
    put_desc(32'hD0, 32'h6000, 4,  32'h2);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain3();
    t_idle_abort();
    t_single();
    t_dir();
    t_mem_err();
    t_xfer_err();
    t_abort();
    t_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule